// File: doc/BRIEF.md
# USB Endpoint Transmit Packet Buffer

This block is the transmit-side byte store of one device endpoint. A processor or DMA engine pushes bytes in on a valid/ready stream and commits them as packets, either by a commit strobe or automatically once a full maximum-size packet has arrived. The serial engine pulls the oldest committed packet out on a second valid/ready stream. It then reports the result: an acknowledge retires the packet, a failure rewinds it so it can be resent, and an isochronous endpoint retires the packet as soon as its last byte leaves.

The buffering mode follows from the configured maximum packet size. A packet larger than half the buffer allows only one queued packet. A smaller one allows two, so transfers can run back to back. Flush, or end-of-setup on a control endpoint, discards the oldest packet as if it had been sent. The status outputs tell the writer whether it may load another packet and whether any committed data remains.

Back-pressure: on the write stream a byte is taken on a cycle with `wr_valid` and `wr_ready` both high. `wr_ready` falls only when every storage byte is occupied. A byte offered while `wr_ready` is low is dropped and is not held. On the read stream, `rd_data` and `rd_last` hold steady while `rd_valid` is high and `rd_ready` is low.

Top module: `usbtx_fifo`

## Requirements
- R1: The mode is dual when `cfg_ctrl`=0 and `cfg_maxp` <= DEPTH/2, and single otherwise. In single mode `pkt_rdy` rises with the first committed packet. In dual mode it stays low until a second packet is committed.
- R2: Bytes leave on the read stream in the order they were written, including when the storage position wraps past DEPTH.
- R3: A `commit_req` pulse commits all bytes written since the last commit as one packet of that length, including a short packet. A commit while the packet queue is at capacity is ignored.
- R4: With `cfg_auto`=1, the write that brings the uncommitted byte count to `cfg_maxp` commits the packet without a strobe.
- R5: In single mode with `cfg_iso`=0, `pkt_rdy` stays high after the last byte is read and falls one cycle after `tx_ack`.
- R6: With `cfg_iso`=1, a packet retires in the cycle its last byte is accepted, with no acknowledge.
- R7: In dual mode, `pkt_rdy` is high only while two packets are queued. It falls as soon as one of them retires.
- R8: `tx_fail` after a packet's last byte restarts the read stream at the first byte of the same packet.
- R9: `flush_req` retires only the oldest queued packet. `pkt_rdy` and `not_empty` then reflect what remains.
- R10: With `cfg_ctrl`=1 the mode is always single, and `setup_end` retires the queued packet like a flush.
- R11: When DEPTH bytes are stored, `wr_ready` is low. An offered byte is then discarded and sets the sticky `overrun` flag.
- R12: `not_empty` is high exactly while at least one committed packet remains. Uncommitted bytes do not raise it, and `rd_valid` is never high without it.
- R13: While `rd_valid` is high and `rd_ready` low, `rd_data` and `rd_last` hold. `rd_last` marks a packet's final byte. A zero-length packet is a single beat with `rd_last`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_maxp | input | 7 | Maximum packet size in bytes (1..DEPTH) |
| cfg_auto | input | 1 | Commit automatically at cfg_maxp bytes |
| cfg_iso | input | 1 | Isochronous endpoint: success assumed |
| cfg_ctrl | input | 1 | Control endpoint: single mode, setup_end honoured |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Storage has room for a byte |
| wr_data | input | 8 | Write byte |
| commit_req | input | 1 | Commit written bytes as a packet |
| flush_req | input | 1 | Retire oldest packet |
| setup_end | input | 1 | Control transfer aborted (control endpoint only) |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Serial engine accepts the byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final beat of the packet |
| tx_ack | input | 1 | Host acknowledged the sent packet |
| tx_fail | input | 1 | Send failed, resend required |
| pkt_rdy | output | 1 | No further packet may be loaded now |
| not_empty | output | 1 | At least one committed packet stored |
| overrun | output | 1 | Sticky: a byte was offered while full |

## Verification
The hardest state to reach from the ports is a flush that hits while two packets are queued. Telling it apart from a whole-buffer clear needs the surviving packet's bytes to come out intact afterward. The bench first commits two distinct packets in dual mode and retires one, then loads a third so the queue holds two again, and then flushes. The scoreboard expects only the newest packet's bytes. Pointer wrap is reached by streaming several isochronous maximum-size packets back to back, so more than DEPTH bytes pass through.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  typedef enum logic {MODE_SINGLE = 1'b0, MODE_DUAL = 1'b1} bufmode_e;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/usbtx_store.sv
module usbtx_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/usbtx_lenq.sv
module usbtx_lenq #(
  parameter int unsigned LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic          accept,
  output logic [LW-1:0] head_len,
  output logic [1:0]    qcnt
);
  logic [LW-1:0] len0, len1;
  logic [1:0]    cap;

  assign cap      = dual ? 2'd2 : 2'd1;
  assign accept   = push && ((qcnt < cap) || pop);
  assign head_len = len0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qcnt <= 2'd0;
      len0 <= '0;
      len1 <= '0;
    end else begin
      case ({pop, accept})
        2'b10: begin
          len0 <= len1;
          qcnt <= qcnt - 2'd1;
        end
        2'b01: begin
          if (qcnt == 2'd0) len0 <= push_len;
          else              len1 <= push_len;
          qcnt <= qcnt + 2'd1;
        end
        2'b11: begin
          if (qcnt == 2'd1) len0 <= push_len;
          else begin
            len0 <= len1;
            len1 <= push_len;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: single mode never holds more than one packet
  p_single_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dual |-> qcnt <= 2'd1);
  // R3: queue never exceeds two entries
  p_queue_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt != 2'd3);
  // R9: a pop never happens on an empty queue
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> qcnt != 2'd0);
endmodule

// File: rtl/usbtx_fifo.sv
module usbtx_fifo
  import usbtx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     cfg_maxp,
  input  logic              cfg_auto,
  input  logic              cfg_iso,
  input  logic              cfg_ctrl,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              commit_req,
  input  logic              flush_req,
  input  logic              setup_end,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_last,
  input  logic              tx_ack,
  input  logic              tx_fail,
  output logic              pkt_rdy,
  output logic              not_empty,
  output logic              overrun
);
  logic [LW-1:0] wptr, base, rd_off, pend, fill, head_len, push_len;
  logic [1:0]    qcnt;
  logic          await_res, full, wr_fire, rd_fire, last_fire;
  logic          drop, pop, rewind, push, accept, auto_hit;
  bufmode_e      mode;

  assign mode      = (!cfg_ctrl && (cfg_maxp <= LW'(DEPTH / 2))) ? MODE_DUAL : MODE_SINGLE;
  assign fill      = wptr - base;
  assign full      = (fill == LW'(DEPTH));
  assign wr_ready  = !full;
  assign wr_fire   = wr_valid && !full;

  assign rd_valid  = (qcnt != 2'd0) && !await_res;
  assign rd_last   = (({1'b0, rd_off} + (LW + 1)'(1)) >= {1'b0, head_len});
  assign rd_fire   = rd_valid && rd_ready;
  assign last_fire = rd_fire && rd_last;

  assign drop      = (flush_req || (cfg_ctrl && setup_end)) && (qcnt != 2'd0);
  assign pop       = drop || (cfg_iso ? last_fire : (await_res && tx_ack));
  assign rewind    = await_res && tx_fail && !pop;

  assign push_len  = pend + LW'(wr_fire);
  assign auto_hit  = cfg_auto && wr_fire && (push_len >= cfg_maxp);
  assign push      = commit_req || auto_hit;

  assign not_empty = (qcnt != 2'd0);
  assign pkt_rdy   = (mode == MODE_DUAL) ? (qcnt == 2'd2) : (qcnt != 2'd0);

  usbtx_store #(.DEPTH(DEPTH), .DW(BYTE_W)) store_i (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (base[AW-1:0] + rd_off[AW-1:0]),
    .rdata (rd_data)
  );

  usbtx_lenq #(.LW(LW)) lenq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual     (mode == MODE_DUAL),
    .push     (push),
    .push_len (push_len),
    .pop      (pop),
    .accept   (accept),
    .head_len (head_len),
    .qcnt     (qcnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      base      <= '0;
      rd_off    <= '0;
      pend      <= '0;
      await_res <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (wr_fire) wptr <= wptr + LW'(1);
      if (wr_valid && full) overrun <= 1'b1;
      pend <= accept ? '0 : push_len;
      if (pop) base <= base + head_len;
      if (pop || rewind) begin
        rd_off    <= '0;
        await_res <= 1'b0;
      end else begin
        if (rd_fire && (head_len != '0)) rd_off <= rd_off + LW'(1);
        if (last_fire && !cfg_iso) await_res <= 1'b1;
      end
    end
  end

  // R13: a stalled read beat holds its contents
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !flush_req && !(cfg_ctrl && setup_end)
    |=> rd_valid && $stable(rd_data) && $stable(rd_last));
  // R11: an offer while full raises overrun
  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> overrun);
  // R8: a failure restarts the stream
  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    await_res && tx_fail && !tx_ack && !flush_req && !(cfg_ctrl && setup_end)
    |=> rd_valid);
  // R12: no read data without a committed packet
  p_no_read_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> !rd_valid);
  // R4: reaching maxp with an empty queue commits a packet
  p_auto_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto && wr_fire && (push_len == cfg_maxp) && (qcnt == 2'd0) && !flush_req
    |=> not_empty);
endmodule

// File: tb/usbtx_fifo_tb_top.sv
module usbtx_fifo_tb_top;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned LW    = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0] cfg_maxp;
  logic cfg_auto, cfg_iso, cfg_ctrl;
  logic wr_valid, wr_ready, commit_req, flush_req, setup_end;
  logic [7:0] wr_data, rd_data;
  logic rd_valid, rd_ready, rd_last, tx_ack, tx_fail;
  logic pkt_rdy, not_empty, overrun;

  int vecs = 0;
  int errs = 0;
  logic [9:0] sb [$];   // {zero_len, last, data}

  always #4 clk = ~clk;

  usbtx_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_maxp(cfg_maxp), .cfg_auto(cfg_auto),
    .cfg_iso(cfg_iso), .cfg_ctrl(cfg_ctrl), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .commit_req(commit_req),
    .flush_req(flush_req), .setup_end(setup_end), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .tx_ack(tx_ack), .tx_fail(tx_fail), .pkt_rdy(pkt_rdy),
    .not_empty(not_empty), .overrun(overrun)
  );

  // monitor: compares every accepted read beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      vecs++;
      if (sb.size() == 0) begin
        errs++;
        $display("FAIL R2: unexpected beat data=%h expected none", rd_data);
      end else begin
        logic [9:0] e;
        e = sb.pop_front();
        if (rd_last !== e[8] || (!e[9] && rd_data !== e[7:0])) begin
          errs++;
          $display("FAIL R2/R13: got last=%b data=%h expected last=%b data=%h",
                   rd_last, rd_data, e[8], e[7:0]);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    @(negedge clk);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [LW-1:0] maxp, input logic au,
                          input logic iso, input logic ctl);
    rst_n = 1'b0; cfg_maxp = maxp; cfg_auto = au; cfg_iso = iso; cfg_ctrl = ctl;
    wr_valid = 0; wr_data = 0; commit_req = 0; flush_req = 0; setup_end = 0;
    rd_ready = 0; tx_ack = 0; tx_fail = 0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_bytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = seed + 8'(i);
      step();
    end
    wr_valid = 1'b0;
  endtask

  task automatic expect_pkt(input int n, input logic [7:0] seed);
    if (n == 0) sb.push_back({1'b1, 1'b1, 8'h00});
    for (int i = 0; i < n; i++)
      sb.push_back({1'b0, (i == n - 1), seed + 8'(i)});
  endtask

  task automatic drain();
    int g = 0;
    rd_ready = 1'b1;
    while (sb.size() != 0 && g < 500) begin step(); g++; end
    rd_ready = 1'b0;
    if (sb.size() != 0) begin
      errs++; vecs++;
      $display("FAIL R2: %0d beats never arrived, expected 0", sb.size());
      sb.delete();
    end
  endtask

  task automatic pulse_commit(); commit_req = 1; step(); commit_req = 0; endtask
  task automatic pulse_ack();    tx_ack = 1;     step(); tx_ack = 0;     endtask
  task automatic pulse_fail();   tx_fail = 1;    step(); tx_fail = 0;    endtask
  task automatic pulse_flush();  flush_req = 1;  step(); flush_req = 0;  endtask

  initial begin
    logic [7:0] held;
    do_reset(7'd40, 0, 0, 0);
    chk(pkt_rdy, 0, "R1 reset");
    chk(not_empty, 0, "R12 reset");
    chk(overrun, 0, "R11 reset");
    chk(wr_ready, 1, "R11 reset");

    // single mode, manual commit, short packet
    wr_bytes(5, 8'h10); step();
    chk(not_empty, 0, "R12 uncommitted");
    pulse_commit();
    chk(pkt_rdy, 1, "R1 single");
    chk(not_empty, 1, "R3 commit");
    held = rd_data;
    step();
    chk(rd_valid, 1, "R13 stall valid");
    chk(rd_data == held && held == 8'h10, 1, "R13 stall data");
    expect_pkt(5, 8'h10); drain(); step();
    chk(pkt_rdy, 1, "R5 held until ack");
    pulse_fail();
    expect_pkt(5, 8'h10); drain();      // R8 resend
    pulse_ack();
    chk(pkt_rdy, 0, "R5 ack clears");
    chk(not_empty, 0, "R5 empty");

    // dual mode, flush of oldest
    do_reset(7'd16, 0, 0, 0);
    wr_bytes(16, 8'h20); pulse_commit();
    chk(pkt_rdy, 0, "R7 one queued");
    wr_bytes(10, 8'h40); pulse_commit();
    chk(pkt_rdy, 1, "R7 two queued");
    expect_pkt(16, 8'h20); drain(); pulse_ack();
    chk(pkt_rdy, 0, "R7 one retired");
    chk(not_empty, 1, "R12 one left");
    wr_bytes(4, 8'h60); pulse_commit();
    chk(pkt_rdy, 1, "R7 refilled");
    pulse_flush();
    chk(pkt_rdy, 0, "R9 flush oldest");
    chk(not_empty, 1, "R9 newest kept");
    expect_pkt(4, 8'h60); drain(); pulse_ack();   // R9 survivor bytes
    chk(not_empty, 0, "R9 final");

    // auto commit, isochronous, pointer wrap
    do_reset(7'd16, 1, 1, 0);
    wr_bytes(15, 8'h80); step();
    chk(not_empty, 0, "R4 below maxp");
    wr_bytes(1, 8'h8F); step();
    chk(not_empty, 1, "R4 at maxp");
    expect_pkt(16, 8'h80); drain();
    chk(not_empty, 0, "R6 iso retire");
    for (int k = 0; k < 3; k++) begin
      wr_bytes(16, 8'(8'hA0 + 8'(k * 32)));
      wr_bytes(16, 8'(8'hB0 + 8'(k * 32)));
      chk(pkt_rdy, 1, "R7 auto two");
      expect_pkt(16, 8'(8'hA0 + 8'(k * 32)));
      expect_pkt(16, 8'(8'hB0 + 8'(k * 32)));
      drain();                                     // R2 wrap
    end
    chk(not_empty, 0, "R6 all retired");

    // overrun when full
    do_reset(7'd64, 0, 0, 0);
    wr_bytes(64, 8'h00); step();
    chk(wr_ready, 0, "R11 full");
    wr_bytes(1, 8'hEE); step();
    chk(overrun, 1, "R11 sticky");
    pulse_commit();
    expect_pkt(64, 8'h00); drain(); pulse_ack();   // R11 dropped byte absent
    chk(overrun, 1, "R11 stays");
    chk(wr_ready, 1, "R11 room");

    // zero-length packet
    pulse_commit();
    chk(not_empty, 1, "R13 zero length");
    expect_pkt(0, 8'h00); drain(); pulse_ack();
    chk(not_empty, 0, "R13 zlp retired");

    // control endpoint
    do_reset(7'd8, 0, 0, 1);
    wr_bytes(3, 8'h33); pulse_commit();
    chk(pkt_rdy, 1, "R10 single forced");
    setup_end = 1; step(); setup_end = 0;
    chk(pkt_rdy, 0, "R10 setup_end");
    chk(not_empty, 0, "R10 empty");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule